// File: doc/BRIEF.md
# Peripheral Protection Attribute Register Bank

This block keeps one 2-bit access attribute for every securable peripheral on a chip, plus a per-peripheral freeze bit. Trusted software writes the attributes over a simple 32-bit register bus that carries a secure-access flag. The bank drives all attributes onto a flat output vector for the fabric's filters. It also answers a combinational query: given a peripheral number and a transaction type (secure or not, read or write), it reports whether that transaction is allowed. Two read-only words describe the instance: a hardware configuration word holding the implemented counts, and a version word.

Attributes are packed sixteen per word, two bits each. The word for peripheral n sits at offset 0x010 + 4*(n/16), and its field starts at bit 2*(n mod 16). Freeze bits are packed thirty-two per word, starting at offset 0x030. The bit for peripheral n is bit (n mod 32) of the word at 0x030 + 4*(n/32). A freeze bit is write-one-to-set and is cleared only by reset. The peripheral count is a parameter (at most 128, so the attribute words end below 0x030). Register reads return data one clock after the request.

Top module: `prot_attr_bank`

## Requirements
- R1: After reset, every attribute field and every freeze bit is 0, `attr_out` is all zero, and `bus_rdata` is 0.
- R2: A secure write (`bus_sel`=1, `bus_wr`=1, `bus_sec`=1) to offset 0x010 + 4*k loads, for each implemented peripheral n with n/16 = k, bits [2*(n mod 16)+1 : 2*(n mod 16)] of the write data into that peripheral's attribute. A later read of the same word returns the stored fields in the same positions.
- R3: A secure write to offset 0x030 + 4*k sets the freeze bit of peripheral 32*k + b for every data bit b that is 1. Data bits that are 0 leave freeze bits unchanged, and a set freeze bit stays set until reset.
- R4: An attribute write skips the field of a frozen peripheral, while unfrozen fields in the same word still take the written value.
- R5: A write with `bus_sec`=0 changes no attribute and no freeze bit. A read with `bus_sec`=0 returns the same data as a secure read.
- R6: A read of offset 0x3F0 returns the number of memory zones in bits [7:0], the number of securable peripherals in bits [15:8] and the number of securable bus masters in bits [23:16], with bits [31:24] zero.
- R7: A read of offset 0x3F4 returns the version parameter, with the revision in bits [7:0].
- R8: `chk_allow` follows the attribute code of `chk_id`. Code 0 allows secure accesses only. Code 1 allows any read and secure writes. Code 2 allows nothing. Code 3 allows everything.
- R9: `chk_allow` is 0 for any `chk_id` at or above the peripheral count. Attribute and freeze positions of unimplemented peripherals read as 0, and any offset not listed here reads as 0.
- R10: `bus_rdata` is loaded on the clock edge that samples a read (`bus_sel`=1, `bus_wr`=0) and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sec | input | 1 | Access comes from the secure world |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| chk_id | input | ID_W | Peripheral number being queried |
| chk_sec | input | 1 | Queried transaction is secure |
| chk_wr | input | 1 | Queried transaction is a write |
| chk_allow | output | 1 | Queried transaction is permitted |
| attr_out | output | 2*N_PERIPH | Attribute of peripheral n at bits [2n+1:2n] |

## Verification
Writes land on the edge that samples them, so the bench updates its model and compares `attr_out` at the following falling edge. Read data appears one edge after the request, and the bench samples `bus_rdata` at the falling edge after that edge. The hold rule is checked by sampling again after cycles without a read. The access query is combinational, so the bench compares `chk_allow` a short delay after driving the query at a falling edge, when the attribute state is stable.

// File: rtl/prot_attr_pkg.sv
`timescale 1ns/1ps
package prot_attr_pkg;
  typedef enum logic [1:0] {
    MODE_SEC_ONLY = 2'd0,
    MODE_NSRD_SWR = 2'd1,
    MODE_ISOLATE  = 2'd2,
    MODE_OPEN     = 2'd3
  } prot_mode_e;

  localparam int unsigned ATTR_BASE      = 32'h010;
  localparam int unsigned LOCK_BASE      = 32'h030;
  localparam int unsigned CFG_OFS        = 32'h3F0;
  localparam int unsigned VER_OFS        = 32'h3F4;
  localparam int unsigned IDS_PER_ATTR_W = 16;
  localparam int unsigned IDS_PER_LOCK_W = 32;
endpackage

// File: rtl/prot_attr_store.sv
`timescale 1ns/1ps
module prot_attr_store
  import prot_attr_pkg::*;
#(
  parameter int N_PERIPH = 40,
  parameter int ADDR_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  output logic [2*N_PERIPH-1:0] attr_q,
  output logic [N_PERIPH-1:0]   lock_q
);
  logic [2*N_PERIPH-1:0] attr_d;
  logic [N_PERIPH-1:0]   lock_d;

  // next-state per peripheral
  for (genvar i = 0; i < N_PERIPH; i++) begin : g_id
    localparam int AW = i / IDS_PER_ATTR_W;
    localparam int AB = (i % IDS_PER_ATTR_W) * 2;
    localparam int LW = i / IDS_PER_LOCK_W;
    localparam int LB = i % IDS_PER_LOCK_W;
    logic attr_hit;
    logic lock_hit;
    assign attr_hit = (wr_addr == ADDR_W'(ATTR_BASE + 4 * AW)) && !lock_q[i];
    assign lock_hit = (wr_addr == ADDR_W'(LOCK_BASE + 4 * LW));
    assign attr_d[2*i +: 2] = attr_hit ? wr_data[AB +: 2] : attr_q[2*i +: 2];
    assign lock_d[i] = lock_q[i] | (lock_hit & wr_data[LB]);
  end

  // state registers, enabled by secure writes only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= '0;
      lock_q <= '0;
    end else if (wr_en) begin
      attr_q <= attr_d;
      lock_q <= lock_d;
    end
  end
endmodule

// File: rtl/prot_read_mux.sv
`timescale 1ns/1ps
module prot_read_mux
  import prot_attr_pkg::*;
#(
  parameter int          N_PERIPH  = 40,
  parameter int          N_ZONES   = 2,
  parameter int          N_MASTERS = 4,
  parameter logic [31:0] VERSION   = 32'h0000_0021,
  parameter int          ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*N_PERIPH-1:0] attr_q,
  input  logic [N_PERIPH-1:0]   lock_q,
  output logic [31:0]           rd_word
);
  localparam int ATTR_WORDS = (N_PERIPH + IDS_PER_ATTR_W - 1) / IDS_PER_ATTR_W;
  localparam int LOCK_WORDS = (N_PERIPH + IDS_PER_LOCK_W - 1) / IDS_PER_LOCK_W;
  localparam logic [31:0] CFG_WORD = {8'h00, 8'(N_MASTERS), 8'(N_PERIPH), 8'(N_ZONES)};

  logic [32*ATTR_WORDS-1:0] attr_pad;
  logic [32*LOCK_WORDS-1:0] lock_pad;

  assign attr_pad = (32*ATTR_WORDS)'(attr_q);
  assign lock_pad = (32*LOCK_WORDS)'(lock_q);

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < ATTR_WORDS; w++) begin
      if (addr == ADDR_W'(ATTR_BASE + 4 * w)) rd_word = attr_pad[32*w +: 32];
    end
    for (int w = 0; w < LOCK_WORDS; w++) begin
      if (addr == ADDR_W'(LOCK_BASE + 4 * w)) rd_word = lock_pad[32*w +: 32];
    end
    if (addr == ADDR_W'(CFG_OFS)) rd_word = CFG_WORD;
    if (addr == ADDR_W'(VER_OFS)) rd_word = VERSION;
  end
endmodule

// File: rtl/prot_access_check.sv
`timescale 1ns/1ps
module prot_access_check
  import prot_attr_pkg::*;
#(
  parameter int N_PERIPH = 40,
  parameter int ID_W     = 7
) (
  input  logic [2*N_PERIPH-1:0] attr_q,
  input  logic [ID_W-1:0]       chk_id,
  input  logic                  chk_sec,
  input  logic                  chk_wr,
  output logic                  chk_allow
);
  logic       id_ok;
  prot_mode_e mode;

  assign id_ok = (32'(chk_id) < N_PERIPH);

  always_comb begin
    mode = MODE_SEC_ONLY;
    for (int i = 0; i < N_PERIPH; i++) begin
      if (32'(chk_id) == i) mode = prot_mode_e'(attr_q[2*i +: 2]);
    end
  end

  always_comb begin
    unique case (mode)
      MODE_SEC_ONLY: chk_allow = id_ok & chk_sec;
      MODE_NSRD_SWR: chk_allow = id_ok & (chk_sec | ~chk_wr);
      MODE_ISOLATE:  chk_allow = 1'b0;
      MODE_OPEN:     chk_allow = id_ok;
      default:       chk_allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/prot_attr_bank.sv
`timescale 1ns/1ps
module prot_attr_bank #(
  parameter int          N_PERIPH  = 40,
  parameter int          N_ZONES   = 2,
  parameter int          N_MASTERS = 4,
  parameter logic [31:0] VERSION   = 32'h0000_0021,
  parameter int          ADDR_W    = 12,
  parameter int          ID_W      = $clog2(N_PERIPH) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic                  bus_sec,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [ID_W-1:0]       chk_id,
  input  logic                  chk_sec,
  input  logic                  chk_wr,
  output logic                  chk_allow,
  output logic [2*N_PERIPH-1:0] attr_out
);
  logic                  wr_en;
  logic                  rd_en;
  logic [2*N_PERIPH-1:0] attr_q;
  logic [N_PERIPH-1:0]   lock_q;
  logic [31:0]           rd_word;

  assign wr_en = bus_sel & bus_wr & bus_sec;
  assign rd_en = bus_sel & ~bus_wr;

  prot_attr_store #(.N_PERIPH(N_PERIPH), .ADDR_W(ADDR_W)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .attr_q  (attr_q),
    .lock_q  (lock_q)
  );

  prot_read_mux #(
    .N_PERIPH(N_PERIPH), .N_ZONES(N_ZONES), .N_MASTERS(N_MASTERS),
    .VERSION(VERSION), .ADDR_W(ADDR_W)
  ) i_rmux (
    .addr    (bus_addr),
    .attr_q  (attr_q),
    .lock_q  (lock_q),
    .rd_word (rd_word)
  );

  prot_access_check #(.N_PERIPH(N_PERIPH), .ID_W(ID_W)) i_chk (
    .attr_q    (attr_q),
    .chk_id    (chk_id),
    .chk_sec   (chk_sec),
    .chk_wr    (chk_wr),
    .chk_allow (chk_allow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_word;
  end

  assign attr_out = attr_q;
endmodule

// File: rtl/prot_attr_bank_chk.sv
`timescale 1ns/1ps
module prot_attr_bank_chk #(
  parameter int N_PERIPH = 40,
  parameter int ADDR_W   = 12,
  parameter int ID_W     = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic                  bus_sec,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [31:0]           bus_rdata,
  input logic [ID_W-1:0]       chk_id,
  input logic                  chk_sec,
  input logic                  chk_allow,
  input logic [2*N_PERIPH-1:0] attr_vec,
  input logic [N_PERIPH-1:0]   lock_vec
);
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_vec & $past(lock_vec)) == $past(lock_vec))); // R3

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_frz
    AST_FROZEN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      lock_vec[i] |=> $stable(attr_vec[2*i +: 2])); // R4
  end

  AST_NONSEC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_sec) |=> ($stable(attr_vec) && $stable(lock_vec))); // R5

  AST_SEC_ONLY_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(chk_id) < N_PERIPH) && !chk_sec && attr_vec[2*chk_id +: 2] == 2'd0) |-> !chk_allow); // R8

  AST_ISOLATE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(chk_id) < N_PERIPH) && attr_vec[2*chk_id +: 2] == 2'd2) |-> !chk_allow); // R8

  AST_BAD_ID_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(chk_id) >= N_PERIPH) |-> !chk_allow); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata)); // R10

  logic unused_ok;
  assign unused_ok = ^bus_addr;
endmodule

bind prot_attr_bank prot_attr_bank_chk #(
  .N_PERIPH(N_PERIPH), .ADDR_W(ADDR_W), .ID_W(ID_W)
) i_prot_attr_bank_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_sec   (bus_sec),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .chk_id    (chk_id),
  .chk_sec   (chk_sec),
  .chk_allow (chk_allow),
  .attr_vec  (attr_q),
  .lock_vec  (lock_q)
);

// File: tb/test_prot_attr_bank.sv
`timescale 1ns/1ps
module test_prot_attr_bank;
  localparam int          NP   = 40;
  localparam int          NZ   = 2;
  localparam int          NM   = 4;
  localparam logic [31:0] VER  = 32'h0000_0021;
  localparam int          AW   = 12;
  localparam int          IW   = $clog2(NP) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr, bus_sec;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [IW-1:0] chk_id;
  logic          chk_sec, chk_wr, chk_allow;
  logic [2*NP-1:0] attr_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [1:0] m_attr [NP];
  bit         m_lock [NP];

  always #2 clk = ~clk; // 250 MHz

  prot_attr_bank #(.N_PERIPH(NP), .N_ZONES(NZ), .N_MASTERS(NM), .VERSION(VER), .ADDR_W(AW))
    i_prot_attr_bank (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_sec(bus_sec),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .chk_id(chk_id), .chk_sec(chk_sec), .chk_wr(chk_wr), .chk_allow(chk_allow),
      .attr_out(attr_out));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [AW-1:0] a);
    logic [31:0] r = '0;
    for (int i = 0; i < NP; i++) begin
      if (a == AW'(32'h010 + 4 * (i / 16))) r[(i % 16) * 2 +: 2] = m_attr[i];
      if (a == AW'(32'h030 + 4 * (i / 32))) r[i % 32] = m_lock[i];
    end
    if (a == AW'(32'h3F0)) r = {8'h00, 8'(NM), 8'(NP), 8'(NZ)};
    if (a == AW'(32'h3F4)) r = VER;
    return r;
  endfunction

  function automatic logic exp_allow(int id, logic sec, logic wr);
    if (id >= NP) return 1'b0;
    case (m_attr[id])
      2'd0: return sec;
      2'd1: return sec | ~wr;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [2*NP-1:0] exp_vec();
    logic [2*NP-1:0] v;
    for (int i = 0; i < NP; i++) v[2*i +: 2] = m_attr[i];
    return v;
  endfunction

  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d, logic sec);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_sec = sec; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (sec) begin
      for (int i = 0; i < NP; i++) begin
        if (a == AW'(32'h010 + 4 * (i / 16)) && !m_lock[i]) m_attr[i] = d[(i % 16) * 2 +: 2];
        if (a == AW'(32'h030 + 4 * (i / 32)) && d[i % 32]) m_lock[i] = 1'b1;
      end
    end
  endtask

  task automatic bus_read(logic [AW-1:0] a, logic sec, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_sec = sec; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic query(string req, int id, logic sec, logic wr);
    @(negedge clk);
    chk_id = IW'(id); chk_sec = sec; chk_wr = wr;
    #1;
    check(req, 32'(chk_allow), 32'(exp_allow(id, sec, wr)));
  endtask

  task automatic read_check(string req, logic [AW-1:0] a, logic sec);
    logic [31:0] d;
    bus_read(a, sec, d);
    check(req, d, exp_read(a));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, hold;
    void'($urandom(32'd1234));
    for (int i = 0; i < NP; i++) begin m_attr[i] = 2'd0; m_lock[i] = 1'b0; end
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_sec = 0; bus_addr = '0; bus_wdata = '0;
    chk_id = '0; chk_sec = 0; chk_wr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 attr_out", 32'(attr_out[31:0]), 32'h0);
    rst_n = 1'b1;
    for (int w = 0; w < 3; w++) read_check("R1 attr word", AW'(32'h010 + 4 * w), 1'b1);
    for (int w = 0; w < 2; w++) read_check("R1 lock word", AW'(32'h030 + 4 * w), 1'b1);
    // R6 R7 identity words
    read_check("R6 cfg", AW'(32'h3F0), 1'b1);
    read_check("R7 version", AW'(32'h3F4), 1'b0);
    // R2 all four codes across word 0
    bus_write(AW'(32'h010), 32'hE4E4_E4E4, 1'b1);
    check("R2 attr_out", 32'(attr_out[31:0]), 32'(exp_vec()));
    read_check("R2 readback", AW'(32'h010), 1'b1);
    // R8 every code, every transaction type
    for (int id = 0; id < 4; id++)
      for (int t = 0; t < 4; t++) query("R8 mode", id, t[0], t[1]);
    // R9 unimplemented ids, partial word, unmapped offsets
    for (int id = NP; id < (1 << IW); id += 5) query("R9 bad id", id, 1'b1, 1'b0);
    bus_write(AW'(32'h018), 32'hFFFF_FFFF, 1'b1);
    read_check("R9 partial attr word", AW'(32'h018), 1'b1);
    read_check("R9 unmapped", AW'(32'h100), 1'b1);
    read_check("R9 gap", AW'(32'h01C), 1'b1);
    // R5 non-secure writes ignored, non-secure reads match
    bus_write(AW'(32'h014), 32'h5555_5555, 1'b0);
    bus_write(AW'(32'h030), 32'hFFFF_FFFF, 1'b0);
    check("R5 attr_out", 32'(attr_out[63:32]), 32'(exp_vec() >> 32));
    read_check("R5 ns read attr", AW'(32'h014), 1'b0);
    read_check("R5 ns read lock", AW'(32'h030), 1'b0);
    // R3 lock id 1 and 35; zero write has no effect
    bus_write(AW'(32'h030), 32'h0000_0002, 1'b1);
    bus_write(AW'(32'h034), 32'h0000_0008, 1'b1);
    bus_write(AW'(32'h030), 32'h0000_0000, 1'b1);
    read_check("R3 lock word0", AW'(32'h030), 1'b1);
    read_check("R3 lock word1", AW'(32'h034), 1'b1);
    // R4 locked field frozen, neighbours update
    bus_write(AW'(32'h010), 32'h0000_0000, 1'b1);
    read_check("R4 frozen field", AW'(32'h010), 1'b1);
    check("R4 id1 code", 32'(attr_out[3:2]), 32'h1);
    // R10 hold without read
    bus_read(AW'(32'h3F4), 1'b1, hold);
    bus_write(AW'(32'h014), 32'h1234_5678, 1'b1);
    @(negedge clk);
    check("R10 hold", bus_rdata, hold);
    // random phase
    for (int k = 0; k < 400; k++) begin
      int op = int'($urandom_range(0, 3));
      logic sec = logic'($urandom_range(0, 3) != 0);
      if (op == 0) begin
        bus_write(AW'(32'h010 + 4 * $urandom_range(0, 2)), $urandom(), sec);
        check("R2 R4 R5 rand attr_out", 32'(attr_out[31:0]), 32'(exp_vec()));
      end else if (op == 1) begin
        d = ($urandom_range(0, 7) == 0) ? (32'h1 << $urandom_range(0, 31)) : 32'h0;
        bus_write(AW'(32'h030 + 4 * $urandom_range(0, 1)), d, sec);
      end else if (op == 2) begin
        read_check("R2 R3 rand read", AW'($urandom_range(0, 5) < 3 ?
                   32'h010 + 4 * $urandom_range(0, 2) : 32'h030 + 4 * $urandom_range(0, 1)), sec);
      end else begin
        query("R8 R9 rand query", int'($urandom_range(0, (1 << IW) - 1)), sec, logic'($urandom_range(0, 1)));
      end
    end
    check("R3 R4 final attr_out", 32'(attr_out[79:48]), 32'(exp_vec() >> 48));
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule